// File: doc/BRIEF.md
# Dual-Mode SPI Register Slave

This block is the serial front end of a peripheral register file. An external master selects the slave, toggles a serial clock in mode (0,0), and sends an 8-bit command byte followed by one or more data bytes. The command byte carries a register address and a direction flag. For a write, each received data byte becomes a one-cycle write strobe to the register file. For a read, the block strobes the register file, loads the returned byte and shifts it back to the master one bit per serial clock. Consecutive data bytes in one selection go to consecutive addresses.

Two wiring modes are supported and chosen by a configuration input that is latched only while the slave is deselected. In full-duplex mode, data comes in on the master-out line and goes back on a separate slave-out line. In half-duplex mode the master-out line is shared. The master drives it for the command. For a read, the slave takes the line over after the eighth rising serial clock edge. The slave-out line stays released in this mode. The block runs on a fast system clock and treats the serial clock and select as signals that are already synchronous to it. It finds serial clock edges by comparing each sample with the one before.

Top module: `dm_spi_reg_slave`

## Requirements
- R1: While reset is held or the slave is deselected, both output enables (`mosi_oe`, `miso_oe`) and both register strobes are low.
- R2: Input bits are taken on rising serial clock edges, most significant bit first. In the command byte, bits 7:3 are the register address and bit 1 is the direction (1 = write, 0 = read).
- R3: For a write, each completed data byte produces exactly one single-cycle `reg_wr_en` pulse, with that byte on `reg_wr_data` and its target address on `reg_addr`.
- R4: For a read, `reg_rd_en` pulses once after the command byte and once after each completed data byte. The fetched byte is sent most significant bit first, and the output bit changes only after a falling serial clock edge, so the master finds data bit k stable before rising edge 8+k.
- R5: The register address advances by one after every data byte and wraps from 31 to 0.
- R6: In full-duplex mode `miso_oe` is high for the whole selection and `mosi_oe` is never high.
- R7: In half-duplex mode `miso_oe` is never high. `mosi_oe` stays low for the command byte and for an entire write. For a read it rises in the system clock cycle after the eighth rising serial clock edge and stays high until deselection.
- R8: Deselecting in the middle of a byte drops both output enables in the same cycle, issues no strobe for the partial byte, and makes the next selection start a fresh command byte.
- R9: The mode input is latched only while deselected. A change during a selection has no effect on that transaction.
- R10: Command bits 2 and 0 are ignored, and a single transaction never issues both kinds of strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hd_mode_cfg | input | 1 | 1 selects half-duplex wiring; latched while deselected |
| ss_n | input | 1 | Slave select, active low |
| sclk | input | 1 | Serial clock, idle low, synchronous to clk |
| mosi_in | input | 1 | Value seen on the master-out (or shared) line |
| mosi_out | output | 1 | Value the slave drives on the shared line |
| mosi_oe | output | 1 | Output enable for the shared line |
| miso_out | output | 1 | Value on the slave-out line |
| miso_oe | output | 1 | Output enable for the slave-out line |
| reg_addr | output | 5 | Register address for strobes |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Data for a write strobe |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rd_data | input | 8 | Read data from the register file, valid in the cycle of `reg_rd_en` |

## Verification
The bench builds the block with its default 8-bit byte and 5-bit address. Those widths make the top address 31 reachable in a two-byte burst, so the wrap to address 0 is exercised directly. It uses a serial clock half period of four system clocks. That leaves room for the two-cycle fetch between the eighth rising edge and the following falling edge, and it lets each output-enable change be located to a single cycle around select and clock edges.

// File: rtl/spi_reg_pkg.sv
// Package: shared widths and command-byte field positions for the
// dual-mode SPI register slave. Assumes a byte-wide command and data.
package spi_reg_pkg;
    localparam int unsigned BYTE_W       = 8;
    localparam int unsigned ADDR_W       = 5;
    localparam int unsigned CMD_DIR_BIT  = 1;
    localparam int unsigned CMD_ADDR_LSB = BYTE_W - ADDR_W;
    localparam int unsigned CNT_W        = $clog2(BYTE_W);

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;
endpackage

// File: rtl/spi_sclk_edges.sv
// Serial clock edge finder. Compares sclk with its value one system clock
// earlier and reports single-cycle rise and fall pulses while selected.
// Assumes sclk is already synchronous to clk and that its half period spans
// at least three clk cycles.
module spi_sclk_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_n,
    input  logic sclk,
    output logic rise_o,
    output logic fall_o
);
    logic sclk_q;

    // Keep the previous serial clock sample (idle level is low).
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // Edges count only while the slave is selected.
    always_comb begin
        rise_o = !ss_n &&  sclk && !sclk_q;
        fall_o = !ss_n && !sclk &&  sclk_q;
    end
endmodule

// File: rtl/spi_shift_core.sv
// Bit engine: counts bits within a byte, shifts input in MSB first on rising
// edges, and shifts output out MSB first on falling edges. A load request
// replaces the output shifter. Deselection clears the counter and shifters.
// Assumes a load never coincides with a falling edge.
module spi_shift_core #(
    parameter int unsigned BYTE_W = spi_reg_pkg::BYTE_W,
    localparam int unsigned CNT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_n,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              din_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_data_i,
    output logic              byte_done_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              dout_o
);
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0] rx_sh_q;
    logic [BYTE_W-1:0] tx_sh_q;

    // A byte completes on the rising edge that carries its last bit.
    always_comb begin
        byte_done_o = rise_i && (bit_cnt_q == CNT_W'(BYTE_W - 1));
        byte_o      = {rx_sh_q[BYTE_W-2:0], din_i};
    end

    // Receive side: bit counter and input shifter.
    always_ff @(posedge clk) begin
        if (!rst_n || ss_n) begin
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
        end else if (rise_i) begin
            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
            rx_sh_q   <= {rx_sh_q[BYTE_W-2:0], din_i};
        end
    end

    // Transmit side: load fetched data, present one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || ss_n) begin
            tx_sh_q <= '0;
            dout_o  <= 1'b0;
        end else if (load_i) begin
            tx_sh_q <= load_data_i;
        end else if (fall_i) begin
            dout_o  <= tx_sh_q[BYTE_W-1];
            tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_txn_ctrl.sv
// Transaction controller: decodes the command byte, keeps the running
// register address, issues read and write strobes, latches the wiring mode
// while deselected and marks when the slave owns the shared line.
// Assumes byte completions are at least two clk cycles apart.
module spi_txn_ctrl
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_n,
    input  logic              hd_cfg_i,
    input  logic              byte_done_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              hd_o,
    output logic              rd_dir_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_en_o
);
    phase_e phase_q;
    logic   is_wr_q;

    // Mode latch: follows the configuration input only while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)    hd_o <= 1'b0;
        else if (ss_n) hd_o <= hd_cfg_i;
    end

    // Phase and direction: command first, then data until deselection.
    always_ff @(posedge clk) begin
        if (!rst_n || ss_n) begin
            phase_q  <= PH_CMD;
            is_wr_q  <= 1'b0;
            rd_dir_o <= 1'b0;
        end else if (byte_done_i && phase_q == PH_CMD) begin
            phase_q  <= PH_DATA;
            is_wr_q  <= byte_i[CMD_DIR_BIT];
            rd_dir_o <= !byte_i[CMD_DIR_BIT];
        end
    end

    // Running address: loaded by the command, advanced after each data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
        end else if (byte_done_i && !ss_n) begin
            if (phase_q == PH_CMD)
                addr_o <= byte_i[BYTE_W-1:CMD_ADDR_LSB];
            else if (!is_wr_q)
                addr_o <= addr_o + ADDR_W'(1);
        end else if (wr_en_o) begin
            addr_o <= addr_o + ADDR_W'(1);
        end
    end

    // Strobes: one write per written byte, one read per byte to be sent.
    always_ff @(posedge clk) begin
        if (!rst_n || ss_n) begin
            wr_en_o   <= 1'b0;
            rd_en_o   <= 1'b0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            rd_en_o <= 1'b0;
            if (byte_done_i) begin
                if (phase_q == PH_CMD) begin
                    rd_en_o <= !byte_i[CMD_DIR_BIT];
                end else if (is_wr_q) begin
                    wr_en_o   <= 1'b1;
                    wr_data_o <= byte_i;
                end else begin
                    rd_en_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dm_spi_reg_slave.sv
// Top of the dual-mode SPI register slave. Connects the edge finder, bit
// engine and transaction controller, and forms both pin output enables,
// which drop at once on deselection or reset. Assumes the register file
// answers a read strobe combinationally in the same cycle.
module dm_spi_reg_slave
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd_mode_cfg,
    input  logic              ss_n,
    input  logic              sclk,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    output logic              miso_out,
    output logic              miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wr_data,
    output logic              reg_rd_en,
    input  logic [BYTE_W-1:0] reg_rd_data
);
    logic              rise, fall;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              dout;
    logic              hd_q;
    logic              rd_dir;

    spi_sclk_edges u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .ss_n   (ss_n),
        .sclk   (sclk),
        .rise_o (rise),
        .fall_o (fall)
    );

    spi_shift_core #(.BYTE_W(BYTE_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .ss_n        (ss_n),
        .rise_i      (rise),
        .fall_i      (fall),
        .din_i       (mosi_in),
        .load_i      (reg_rd_en),
        .load_data_i (reg_rd_data),
        .byte_done_o (byte_done),
        .byte_o      (rx_byte),
        .dout_o      (dout)
    );

    spi_txn_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ss_n        (ss_n),
        .hd_cfg_i    (hd_mode_cfg),
        .byte_done_i (byte_done),
        .byte_i      (rx_byte),
        .hd_o        (hd_q),
        .rd_dir_o    (rd_dir),
        .addr_o      (reg_addr),
        .wr_en_o     (reg_wr_en),
        .wr_data_o   (reg_wr_data),
        .rd_en_o     (reg_rd_en)
    );

    // Pin drivers: one data bit feeds both lines, the enables pick the owner.
    always_comb begin
        mosi_out = dout;
        miso_out = dout;
        miso_oe  = rst_n && !ss_n && !hd_q;
        mosi_oe  = rst_n && !ss_n &&  hd_q && rd_dir;
    end
endmodule

// File: rtl/dm_spi_reg_slave_chk.sv
// Checker for the dual-mode SPI register slave, bound to every instance.
module dm_spi_reg_slave_chk
    import spi_reg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ss_n,
    input logic              sclk,
    input logic              fall,
    input logic              hd_q,
    input logic              mosi_oe,
    input logic              miso_oe,
    input logic              miso_out,
    input logic              reg_wr_en,
    input logic              reg_rd_en,
    input logic [ADDR_W-1:0] reg_addr
);
    // R8
    desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> (!mosi_oe && !miso_oe));

    // R6
    fd_no_shared_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hd_q |-> !mosi_oe);

    // R7
    hd_no_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hd_q |-> !miso_oe);

    // R7
    hd_takeover_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mosi_oe) |-> ($past(sclk) && !ss_n));

    // R3
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R5
    wr_addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_addr == ADDR_W'($past(reg_addr) + ADDR_W'(1))));

    // R10
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    // R4
    out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n && $past(!ss_n) && !$stable(miso_out)) |-> $past(fall));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n && $past(!ss_n)) |-> $stable(hd_q));
endmodule

bind dm_spi_reg_slave dm_spi_reg_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ss_n      (ss_n),
    .sclk      (sclk),
    .fall      (fall),
    .hd_q      (hd_q),
    .mosi_oe   (mosi_oe),
    .miso_oe   (miso_oe),
    .miso_out  (miso_out),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr)
);

// File: tb/dm_spi_reg_slave_test.sv
// Directed bench for the dual-mode SPI register slave: one task per scenario.
module dm_spi_reg_slave_test;
    localparam int HP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hd_cfg = 1'b0;
    logic       ss_n = 1'b1;
    logic       sclk = 1'b0;
    logic       m_mosi = 1'b0;
    logic       m_drv = 1'b0;
    logic       mosi_in;
    logic       mosi_out, mosi_oe, miso_out, miso_oe;
    logic [4:0] reg_addr;
    logic       reg_wr_en, reg_rd_en;
    logic [7:0] reg_wr_data, reg_rd_data;

    logic [7:0] regs [32];
    logic [7:0] wbuf [4];
    logic [7:0] rbuf [4];
    int checks = 0, errors = 0;
    int wr_cnt = 0, rd_cnt = 0;
    bit saw_mosi_oe, saw_miso_oe, miso_gap, contention, early_oe, done;

    always #4 clk = ~clk;

    // Shared line: slave value when it drives, else the master's value.
    assign mosi_in     = mosi_oe ? mosi_out : m_mosi;
    assign reg_rd_data = regs[reg_addr];

    dm_spi_reg_slave uut (
        .clk(clk), .rst_n(rst_n), .hd_mode_cfg(hd_cfg), .ss_n(ss_n),
        .sclk(sclk), .mosi_in(mosi_in), .mosi_out(mosi_out),
        .mosi_oe(mosi_oe), .miso_out(miso_out), .miso_oe(miso_oe),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en),
        .reg_rd_data(reg_rd_data)
    );

    // Register file model and strobe counters.
    always @(posedge clk) begin
        if (reg_wr_en) begin
            regs[reg_addr] <= reg_wr_data;
            wr_cnt++;
        end
        if (reg_rd_en) rd_cnt++;
    end

    // Enable monitor while selected.
    always @(negedge clk) begin
        if (!ss_n) begin
            if (mosi_oe) saw_mosi_oe = 1'b1;
            if (miso_oe) saw_miso_oe = 1'b1;
            else         miso_gap    = 1'b1;
            if (mosi_oe && m_drv) contention = 1'b1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One selection: command, nbytes data bytes; stop_bits cuts it short,
    // flip_bit toggles the mode input before that bit.
    task automatic xfer(input bit hd, input logic [7:0] cmd, input int nbytes,
                        input int stop_bits, input int flip_bit);
        int total;
        total = 8 + 8 * nbytes;
        hd_cfg = hd;
        tick(2);
        saw_mosi_oe = 0; saw_miso_oe = 0; miso_gap = 0;
        contention = 0; early_oe = 0;
        ss_n = 1'b0; m_drv = 1'b1;
        tick(2);
        for (int b = 0; b < total; b++) begin
            if (b == stop_bits) break;
            if (b == flip_bit) hd_cfg = ~hd_cfg;
            if (b < 8) m_mosi = cmd[7 - b];
            else       m_mosi = wbuf[(b - 8) / 8][7 - ((b - 8) % 8)];
            tick(HP);
            if (b < 8 && mosi_oe) early_oe = 1'b1;
            if (b >= 8)
                rbuf[(b - 8) / 8][7 - ((b - 8) % 8)] = hd ? mosi_out : miso_out;
            if (b == 7 && hd && !cmd[1]) m_drv = 1'b0;
            sclk = 1'b1;
            tick(HP);
            sclk = 1'b0;
        end
        tick(HP);
        ss_n = 1'b1; m_drv = 1'b0;
        tick(3);
    endtask

    task automatic t_reset;
        chk(!mosi_oe && !miso_oe, "R1", "enables after reset", {mosi_oe, miso_oe}, 0);
        chk(!reg_wr_en && !reg_rd_en, "R1", "strobes after reset", {reg_wr_en, reg_rd_en}, 0);
    endtask

    task automatic t_fd_write;
        int w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
        xfer(1'b0, 8'h1F, 2, 99, 99);   // addr 3, write, bits 2 and 0 set
        chk(regs[3] == 8'hA5, "R2", "fd write byte0", regs[3], 8'hA5);
        chk(regs[4] == 8'h3C, "R5", "fd write byte1 next addr", regs[4], 8'h3C);
        chk(wr_cnt - w0 == 2, "R3", "write strobe count", wr_cnt - w0, 2);
        chk(rd_cnt == r0, "R10", "no read strobe in write", rd_cnt - r0, 0);
        chk(!miso_gap && saw_miso_oe, "R6", "miso_oe held while selected", miso_gap, 0);
        chk(!saw_mosi_oe, "R6", "mosi_oe in full duplex", saw_mosi_oe, 0);
    endtask

    task automatic t_fd_read;
        int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        regs[10] = 8'h96; regs[11] = 8'h41;
        xfer(1'b0, 8'h50, 2, 99, 99);   // addr 10, read
        chk(rbuf[0] == 8'h96, "R4", "fd read byte0", rbuf[0], 8'h96);
        chk(rbuf[1] == 8'h41, "R5", "fd read byte1 next addr", rbuf[1], 8'h41);
        chk(rd_cnt - r0 == 3, "R4", "read strobe count", rd_cnt - r0, 3);
        chk(wr_cnt == w0, "R10", "no write strobe in read", wr_cnt - w0, 0);
    endtask

    task automatic t_hd_write_wrap;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        xfer(1'b1, 8'hFA, 2, 99, 99);   // addr 31, write
        chk(regs[31] == 8'h11, "R3", "hd write addr 31", regs[31], 8'h11);
        chk(regs[0] == 8'h22, "R5", "address wrap to 0", regs[0], 8'h22);
        chk(!saw_mosi_oe, "R7", "mosi_oe in hd write", saw_mosi_oe, 0);
        chk(!saw_miso_oe, "R7", "miso_oe in hd write", saw_miso_oe, 0);
    endtask

    task automatic t_hd_read;
        regs[5] = 8'hC3; regs[6] = 8'h7E;
        xfer(1'b1, 8'h28, 2, 99, 99);   // addr 5, read
        chk(rbuf[0] == 8'hC3, "R7", "hd read byte0", rbuf[0], 8'hC3);
        chk(rbuf[1] == 8'h7E, "R7", "hd read byte1", rbuf[1], 8'h7E);
        chk(!early_oe, "R7", "mosi_oe during command", early_oe, 0);
        chk(saw_mosi_oe && !contention, "R7", "takeover without contention", contention, 0);
        chk(!saw_miso_oe, "R7", "miso_oe in hd read", saw_miso_oe, 0);
    endtask

    task automatic t_abort;
        int w0;
        w0 = wr_cnt;
        regs[7] = 8'h00;
        wbuf[0] = 8'hFF;
        hd_cfg = 1'b0;
        tick(2);
        ss_n = 1'b0;
        tick(2);
        for (int b = 0; b < 12; b++) begin
            m_mosi = (b < 8) ? 1'(8'h3A >> (7 - b)) : 1'b1;
            tick(HP); sclk = 1'b1; tick(HP); sclk = 1'b0;
        end
        tick(1);
        ss_n = 1'b1;
        #1;
        chk(!miso_oe && !mosi_oe, "R8", "enables drop at deselect", miso_oe, 0);
        tick(3);
        chk(wr_cnt == w0, "R8", "no strobe for partial byte", wr_cnt - w0, 0);
        wbuf[0] = 8'h5A;
        xfer(1'b0, 8'h3A, 1, 99, 99);   // addr 7, write
        chk(regs[7] == 8'h5A, "R8", "fresh transaction after abort", regs[7], 8'h5A);
    endtask

    task automatic t_mode_change;
        regs[20] = 8'hE1;
        xfer(1'b0, 8'hA0, 1, 99, 3);    // addr 20 read, mode input flips mid-command
        chk(rbuf[0] == 8'hE1, "R9", "read data after mode flip", rbuf[0], 8'hE1);
        chk(!saw_mosi_oe && !miso_gap, "R9", "full duplex kept", saw_mosi_oe, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 8'(i * 7 + 1);
        tick(4);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_fd_write();
        t_fd_read();
        t_hd_write_wrap();
        t_hd_read();
        t_abort();
        t_mode_change();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule